// File: doc/BRIEF.md
# Width-Selectable Subtractor with Status Flags

This block takes a destination operand and a source operand that have already been fetched and returns the destination minus the source. The operand width is 8, 16, 32 or 64 bits, chosen per operation by a two-bit size code. The result is truncated to that width, and the bits above it are cleared. The source comes either from a register operand or from an immediate field. An immediate is sign-extended to the selected width inside the block, from bit 7 or from bit 31 depending on the source select.

Alongside the difference, the block produces six status flags, each computed at the selected width: carry (unsigned borrow), overflow (signed), sign, zero, auxiliary carry (borrow out of bit 3) and parity of the low result byte. An execution pipeline asserts a valid strobe with the operands. The registered result and flags appear one clock later with a matching valid strobe, and they hold until the next accepted operation.

Top module: `sub_flags_unit`

## Requirements
- R1: The size code `size_sel` is 00 for 8, 01 for 16, 10 for 32 and 11 for 64 bits. `result` equals `dst_val` minus the source, modulo 2 to the selected width, and every result bit above that width is 0. Operand bits above the width have no effect.
- R2: With `src_sel` 00 or 11, the source is `src_val` and `imm_val` has no effect. With `src_sel` 01 or 10, `src_val` has no effect.
- R3: With `src_sel` 01, the source is `imm_val` (32 bits) sign-extended from bit 31.
- R4: With `src_sel` 10, the source is `imm_val[7:0]` sign-extended from bit 7, and `imm_val[31:8]` has no effect.
- R5: `flag_cf` is 1 exactly when the destination, read as unsigned at the selected width, is smaller than the source (a borrow out of the top bit).
- R6: `flag_of` is 1 exactly when the operand sign bits at the selected width differ and the result sign bit differs from the destination sign bit.
- R7: `flag_sf` equals the top bit of the result at the selected width.
- R8: `flag_zf` is 1 exactly when every bit of the masked result is 0.
- R9: `flag_af` equals bit 4 of (destination XOR source XOR result), which is the borrow out of bit 3.
- R10: `flag_pf` is 1 when `result[7:0]` has an even number of ones, at every width.
- R11: `out_valid` is 1 in the cycle after a cycle with `in_valid` high and is 0 otherwise. The result and flags for an accepted operation appear in that same cycle.
- R12: While `in_valid` is low, `result` and all flags keep their last values.
- R13: A synchronous active-high `rst` clears `out_valid`, `result` and all flags, and `in_valid` is ignored while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| size_sel | input | 2 | Operand width code |
| src_sel | input | 2 | Source select: register, wide immediate, byte immediate |
| dst_val | input | 64 | Destination (minuend) operand |
| src_val | input | 64 | Register source (subtrahend) operand |
| imm_val | input | 32 | Immediate field |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Difference, zero above the selected width |
| flag_of | output | 1 | Signed overflow |
| flag_sf | output | 1 | Sign |
| flag_zf | output | 1 | Zero |
| flag_af | output | 1 | Borrow out of bit 3 |
| flag_pf | output | 1 | Even parity of the low result byte |
| flag_cf | output | 1 | Unsigned borrow |

## Verification
The bound assertions check several properties on every cycle. They check the one-cycle valid timing, that the outputs hold while no operation is accepted, and that the upper result bits are cleared at byte width. They also tie the zero, parity and sign flags to the registered result, and check the 64-bit borrow against the registered operands. The overflow and auxiliary-carry values, the two immediate extension modes, and the insensitivity to unused operand bits appear only in the bench scenarios. Those scenarios include borrow across the sign boundary, equal operands, and immediates with junk in their unused bits.

// File: rtl/sub_flags_pkg.sv
package sub_flags_pkg;

  typedef enum logic [1:0] {
    SZ_B8  = 2'b00,
    SZ_B16 = 2'b01,
    SZ_B32 = 2'b10,
    SZ_B64 = 2'b11
  } opsize_e;

  typedef enum logic [1:0] {
    SRC_REG   = 2'b00,
    SRC_IMMW  = 2'b01,
    SRC_IMMB  = 2'b10,
    SRC_REG_A = 2'b11
  } srcsel_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned BASE_W    = 8;

endpackage

// File: rtl/sub_imm_extend.sv
module sub_imm_extend #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IMM_W  = 32
) (
  input  logic [1:0]        src_sel,
  input  logic [DATA_W-1:0] reg_src,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] src_full
);
  import sub_flags_pkg::*;

  localparam int unsigned BYTE_W = 8;

  logic [DATA_W-1:0] imm_wide_ext;
  logic [DATA_W-1:0] imm_byte_ext;

  assign imm_wide_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_byte_ext = {{(DATA_W-BYTE_W){imm[BYTE_W-1]}}, imm[BYTE_W-1:0]};

  always_comb begin
    unique case (srcsel_e'(src_sel))
      SRC_IMMW: src_full = imm_wide_ext;
      SRC_IMMB: src_full = imm_byte_ext;
      default:  src_full = reg_src;
    endcase
  end

endmodule

// File: rtl/sub_lane.sv
module sub_lane #(
  parameter int unsigned W      = 8,
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]          dst,
  input  logic [DATA_W-1:0]          src,
  output logic [DATA_W-1:0]          res,
  output sub_flags_pkg::flags_t      flags
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [W:0]   diff_ext;
  logic [W-1:0] r;
  logic [W-1:0] half_mix;

  assign a        = dst[W-1:0];
  assign b        = src[W-1:0];
  assign diff_ext = {1'b0, a} - {1'b0, b};
  assign r        = diff_ext[W-1:0];
  assign half_mix = a ^ b ^ r;

  always_comb begin
    res        = '0;
    res[W-1:0] = r;
  end

  always_comb begin
    flags.cf = diff_ext[W];
    flags.of = (a[MSB] ^ b[MSB]) & (r[MSB] ^ a[MSB]);
    flags.sf = r[MSB];
    flags.zf = (r == '0);
    flags.af = half_mix[4];
    flags.pf = ~^r[7:0];
  end

endmodule

// File: rtl/sub_flags_unit.sv
module sub_flags_unit #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        size_sel,
  input  logic [1:0]        src_sel,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_of,
  output logic              flag_sf,
  output logic              flag_zf,
  output logic              flag_af,
  output logic              flag_pf,
  output logic              flag_cf
);
  import sub_flags_pkg::*;

  logic [DATA_W-1:0] src_full;
  logic [DATA_W-1:0] lane_res   [NUM_LANES];
  flags_t            lane_flags [NUM_LANES];
  logic [DATA_W-1:0] sel_res;
  flags_t            sel_flags;
  flags_t            flags_q;

  sub_imm_extend #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_ext (
    .src_sel  (src_sel),
    .reg_src  (src_val),
    .imm      (imm_val),
    .src_full (src_full)
  );

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    sub_lane #(
      .W      (BASE_W << gi),
      .DATA_W (DATA_W)
    ) u_lane (
      .dst   (dst_val),
      .src   (src_full),
      .res   (lane_res[gi]),
      .flags (lane_flags[gi])
    );
  end

  always_comb begin
    sel_res   = lane_res[size_sel];
    sel_flags = lane_flags[size_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_q   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= sel_res;
        flags_q <= sel_flags;
      end
    end
  end

  assign flag_of = flags_q.of;
  assign flag_sf = flags_q.sf;
  assign flag_zf = flags_q.zf;
  assign flag_af = flags_q.af;
  assign flag_pf = flags_q.pf;
  assign flag_cf = flags_q.cf;

endmodule

// File: rtl/sub_flags_unit_chk.sv
module sub_flags_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IMM_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        size_sel,
  input logic [1:0]        src_sel,
  input logic [DATA_W-1:0] dst_val,
  input logic [DATA_W-1:0] src_val,
  input logic [IMM_W-1:0]  imm_val,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              flag_of,
  input logic              flag_sf,
  input logic              flag_zf,
  input logic              flag_af,
  input logic              flag_pf,
  input logic              flag_cf
);

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R12
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(flag_cf) && $stable(flag_of)));

  // R1
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b00) |=> (result[DATA_W-1:8] == '0));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_zf == (result == '0)));

  // R10
  parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flag_pf == ~^result[7:0]));

  // R7
  sign_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b00) |=> (flag_sf == result[7]));

  // R7
  sign_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b11) |=> (flag_sf == result[DATA_W-1]));

  // R5
  borrow_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b11 && (src_sel == 2'b00 || src_sel == 2'b11))
      |=> (flag_cf == ($past(dst_val) < $past(src_val))));

endmodule

bind sub_flags_unit sub_flags_unit_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W)
) chk_i (.*);

// File: tb/sub_flags_unit_tb_top.sv
module sub_flags_unit_tb_top;

  typedef struct packed {
    logic [1:0]  sz;
    logic [1:0]  sel;
    logic [63:0] dst;
    logic [63:0] src;
    logic [31:0] imm;
    logic [63:0] res;
    logic [5:0]  flg;   // {of, sf, zf, af, pf, cf}
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 64'h05, 64'h03, 32'h0, 64'h02, 6'b000000},
    '{2'd0, 2'd0, 64'h00, 64'h01, 32'h0, 64'hFF, 6'b010111},
    '{2'd0, 2'd0, 64'h80, 64'h01, 32'h0, 64'h7F, 6'b100100},
    '{2'd0, 2'd0, 64'h7F, 64'hFF, 32'h0, 64'h80, 6'b110001},
    '{2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_1234, 64'h1234, 32'h0, 64'h0, 6'b001010},
    '{2'd2, 2'd3, 64'h0, 64'h1, 32'hFFFF_FFFF, 64'hFFFF_FFFF, 6'b010111},
    '{2'd3, 2'd0, 64'h8000_0000_0000_0000, 64'h1, 32'h0, 64'h7FFF_FFFF_FFFF_FFFF, 6'b100110},
    '{2'd3, 2'd0, 64'h5, 64'h5, 32'h0, 64'h0, 6'b001010},
    '{2'd3, 2'd1, 64'h0, 64'h0, 32'hFFFF_FFFF, 64'h1, 6'b000101},
    '{2'd1, 2'd2, 64'h0, 64'h7, 32'h1234_5680, 64'h0080, 6'b000001},
    '{2'd2, 2'd1, 64'h0, 64'h0, 32'h8000_0000, 64'h8000_0000, 6'b110011},
    '{2'd3, 2'd2, 64'h100, 64'h0, 32'hFFFF_FF7F, 64'h81, 6'b000110},
    '{2'd0, 2'd1, 64'h10, 64'hFF, 32'h10, 64'h0, 6'b001010}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  size_sel;
  logic [1:0]  src_sel;
  logic [63:0] dst_val;
  logic [63:0] src_val;
  logic [31:0] imm_val;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_of, flag_sf, flag_zf, flag_af, flag_pf, flag_cf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sub_flags_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .size_sel  (size_sel),
    .src_sel   (src_sel),
    .dst_val   (dst_val),
    .src_val   (src_val),
    .imm_val   (imm_val),
    .out_valid (out_valid),
    .result    (result),
    .flag_of   (flag_of),
    .flag_sf   (flag_sf),
    .flag_zf   (flag_zf),
    .flag_af   (flag_af),
    .flag_pf   (flag_pf),
    .flag_cf   (flag_cf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    size_sel = v.sz;
    src_sel  = v.sel;
    dst_val  = v.dst;
    src_val  = v.src;
    imm_val  = v.imm;
    in_valid = 1'b1;
  endtask

  task automatic check_vec(input int idx, input vec_t v);
    string p;
    p = $sformatf("vec%0d", idx);
    chk({p, " R11 out_valid"}, {63'd0, out_valid}, 64'd1);
    chk({p, " R1 result"},     result, v.res);
    chk({p, " R6 of"}, {63'd0, flag_of}, {63'd0, v.flg[5]});
    chk({p, " R7 sf"}, {63'd0, flag_sf}, {63'd0, v.flg[4]});
    chk({p, " R8 zf"}, {63'd0, flag_zf}, {63'd0, v.flg[3]});
    chk({p, " R9 af"}, {63'd0, flag_af}, {63'd0, v.flg[2]});
    chk({p, " R10 pf"}, {63'd0, flag_pf}, {63'd0, v.flg[1]});
    chk({p, " R5 cf"}, {63'd0, flag_cf}, {63'd0, v.flg[0]});
  endtask

  function automatic logic [63:0] out_flags();
    return {58'd0, flag_of, flag_sf, flag_zf, flag_af, flag_pf, flag_cf};
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held_res;
    logic [63:0] held_flg;
    rst = 1'b1; in_valid = 1'b0; size_sel = '0; src_sel = '0;
    dst_val = '0; src_val = '0; imm_val = '0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R13 reset result", result, 64'd0);
    chk("R13 reset flags", out_flags(), 64'd0);
    rst = 1'b0;

    // Table: R1..R10 (R2 reg ignores imm, R3 wide imm, R4 byte imm)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(i, VECS[i]);
    end

    // R12: hold while in_valid low, with new operands present
    @(negedge clk);
    drive(VECS[1]);
    @(negedge clk);
    held_res = result;
    held_flg = out_flags();
    in_valid = 1'b0;
    dst_val  = 64'h1234; src_val = 64'h1234; size_sel = 2'd3;
    @(negedge clk);
    chk("R11 idle out_valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R12 hold result", result, held_res);
    chk("R12 hold flags", out_flags(), held_flg);

    // R11: back-to-back operations
    @(negedge clk);
    drive(VECS[3]);
    @(negedge clk);
    drive(VECS[6]);
    chk("R11 b2b first result", result, VECS[3].res);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 b2b second result", result, VECS[6].res);
    chk("R11 b2b second valid", {63'd0, out_valid}, 64'd1);

    // R2: register source ignores imm; R4: byte imm ignores imm[31:8]
    @(negedge clk);
    size_sel = 2'd3; src_sel = 2'd0; dst_val = 64'd9; src_val = 64'd4;
    imm_val = 32'hDEAD_BEEF; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 reg src ignores imm", result, 64'd5);
    @(negedge clk);
    size_sel = 2'd2; src_sel = 2'd2; dst_val = 64'd9; src_val = 64'hFFFF;
    imm_val = 32'hABCD_EF04; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 byte imm ignores high bits", result, 64'd5);

    // R13: reset mid-stream with in_valid high
    @(negedge clk);
    drive(VECS[1]);
    rst = 1'b1;
    @(negedge clk);
    chk("R13 reset clears valid", {63'd0, out_valid}, 64'd0);
    chk("R13 reset clears result", result, 64'd0);
    chk("R13 reset clears flags", out_flags(), 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule